// File: doc/BRIEF.md
# Flash Quad-Word Program Controller

This block controls a small on-chip flash array that is held as internal registers. Software reaches it through a simple word-wide register bus. It writes a target byte address and four data words, and it sets a protection threshold. It then writes the control register with an operation code, the write-enable bit and the start bit. The controller holds its busy bit for a fixed number of clock cycles. At the end of that window it commits the operation to the array, or it refuses the operation and raises the write-error flag.

There are two operations. The quad-word program stores all four data words into one 16-byte-aligned slot. The page erase returns a whole page to all-ones. Each slot keeps a marker that shows whether it has been programmed since its last erase. A marked slot refuses any further program, even one that would only clear more bits. Pages whose number is below the protection threshold cannot be changed at all. The array contents can be read back through a read-only window on the same bus.

Top module: `qwp_flash_ctrl`

## Requirements
- R1: A successful program stores data register 0 at the slot's byte offset +0x0, data register 1 at +0x4, data register 2 at +0x8 and data register 3 at +0xC.
- R2: Address bits [3:0] are ignored when the target slot is chosen. Address bits at or above log2 of the array size in bytes are also ignored; with the default 256-byte array these are bits [31:8].
- R3: A page is protected when its number (byte address / 64 with the defaults) is below the threshold register. A program or erase aimed at a protected page changes nothing and sets the write-error flag. A threshold of 0 protects no page, and a threshold equal to the page count protects every page.
- R4: A slot that has been programmed and not erased since refuses any further program, whatever the data. The write-error flag is set and the contents stay unchanged.
- R5: A control write that has the start bit set and write-enable clear does not start an operation. The busy bit stays 0 and the array is unchanged.
- R6: Operation code 0x2 selects the quad-word program. Code 0x4 erases the addressed page: every word becomes 0xFFFFFFFF and every marker in the page clears. Any other code changes nothing and sets the write-error flag.
- R7: The busy bit (control bit 15) reads 1 for exactly BUSY_CYCLES clock cycles after the accepted start write. It then clears by itself.
- R8: After reset every flash word reads 0xFFFFFFFF, every marker is clear, and the control, address, data and threshold registers read 0.
- R9: Bus writes to any register while the busy bit is set are ignored.
- R10: The write-error flag (control bit 13) clears when a new operation starts. The low-voltage error flag (control bit 12) always reads 0.
- R11: The register map is: control at 0x00 (operation code [3:0], write-enable bit 14, start/busy bit 15), address at 0x04, data 0 to 3 at 0x08 to 0x14, and protection threshold at 0x18. When bus address bit 8 is set, the bus reads flash byte address bus_addr[7:0]; writes to that window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | BUS_AW (9) | Byte address; the top bit selects the flash read window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
The hardest state to reach is a register write that arrives while an operation is still running. The write must be dropped, and the operation must finish with the values it started with. The bench starts a program and, inside the busy window, writes new address, data and threshold values. It then reads the registers and both candidate slots back, to show which values were used. The refused reprogram is reached by first programming a slot successfully and then aiming a second program at a different byte inside the same 16-byte slot. A program issued right after an erase shows that the erase cleared the slot's marker.

// File: rtl/qwp_pkg.sv
package qwp_pkg;

    localparam int WORD_W     = 32;
    localparam int QUAD_WORDS = 4;
    localparam int QUAD_BYTES = 16;

    // register word index (bus_addr[4:2])
    localparam logic [2:0] RI_CTRL  = 3'd0;
    localparam logic [2:0] RI_ADDR  = 3'd1;
    localparam logic [2:0] RI_DATA0 = 3'd2;
    localparam logic [2:0] RI_DATA1 = 3'd3;
    localparam logic [2:0] RI_DATA2 = 3'd4;
    localparam logic [2:0] RI_DATA3 = 3'd5;
    localparam logic [2:0] RI_PROT  = 3'd6;

    // control register bit positions
    localparam int CB_BUSY  = 15;
    localparam int CB_WREN  = 14;
    localparam int CB_WERR  = 13;
    localparam int CB_LVERR = 12;
    localparam int OP_W     = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE       = 4'h0,
        OP_PROG_QUAD  = 4'h2,
        OP_ERASE_PAGE = 4'h4
    } op_code_e;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [QUAD_WORDS-1:0][WORD_W-1:0] quad_t;

    localparam quad_t ERASED_QUAD = '1;

    typedef struct packed {
        logic [OP_W-1:0] op;
        word_t           addr;
        quad_t           data;
    } op_req_t;

    typedef enum logic [1:0] {
        VERDICT_OK,
        VERDICT_PROT,
        VERDICT_REPROG,
        VERDICT_BADOP
    } verdict_e;

    function automatic word_t ctrl_word(input logic busy, input logic wren,
                                        input logic werr, input logic [OP_W-1:0] op);
        word_t w;
        w            = '0;
        w[OP_W-1:0]  = op;
        w[CB_BUSY]   = busy;
        w[CB_WREN]   = wren;
        w[CB_WERR]   = werr;
        w[CB_LVERR]  = 1'b0;
        return w;
    endfunction

endpackage

// File: rtl/qwp_regs.sv
module qwp_regs
    import qwp_pkg::*;
#(
    parameter int BUS_AW = 9,
    parameter int PROT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  word_t             bus_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic              fail,
    output op_req_t           req,
    output logic [PROT_W-1:0] prot_thresh,
    output logic              start,
    output logic              werr,
    output word_t             reg_rdata
);

    logic       reg_space;
    logic [2:0] idx;
    logic       wr_ok;
    logic       wren_q;
    logic [1:0] unused_lsb;

    assign unused_lsb = bus_addr[1:0];
    assign reg_space  = !bus_addr[BUS_AW-1] && (bus_addr[BUS_AW-2:5] == '0);
    assign idx        = bus_addr[4:2];
    assign wr_ok      = bus_we && reg_space && !busy;
    assign start      = wr_ok && (idx == RI_CTRL) && bus_wdata[CB_BUSY] && bus_wdata[CB_WREN];

    always_ff @(posedge clk) begin
        if (rst) begin
            req         <= '0;
            prot_thresh <= '0;
            wren_q      <= 1'b0;
            werr        <= 1'b0;
        end else begin
            if (wr_ok) begin
                case (idx)
                    RI_CTRL: begin
                        req.op <= bus_wdata[OP_W-1:0];
                        wren_q <= bus_wdata[CB_WREN];
                    end
                    RI_ADDR:  req.addr <= bus_wdata;
                    RI_DATA0, RI_DATA1, RI_DATA2, RI_DATA3:
                        req.data[2'(idx - RI_DATA0)] <= bus_wdata;
                    RI_PROT:  prot_thresh <= bus_wdata[PROT_W-1:0];
                    default: ;
                endcase
            end
            if (start)
                werr <= 1'b0;
            else if (done && fail)
                werr <= 1'b1;
        end
    end

    always_comb begin
        case (idx)
            RI_CTRL:  reg_rdata = ctrl_word(busy, wren_q, werr, req.op);
            RI_ADDR:  reg_rdata = req.addr;
            RI_DATA0, RI_DATA1, RI_DATA2, RI_DATA3:
                      reg_rdata = req.data[2'(idx - RI_DATA0)];
            RI_PROT:  reg_rdata = WORD_W'(prot_thresh);
            default:  reg_rdata = '0;
        endcase
        if (!reg_space)
            reg_rdata = '0;
    end

endmodule

// File: rtl/qwp_seq.sv
module qwp_seq
    import qwp_pkg::*;
#(
    parameter int BUSY_CYCLES = 16,
    parameter int NUM_PAGES   = 4,
    parameter int PAGE_QUADS  = 4,
    parameter int QIDX_W      = $clog2(NUM_PAGES * PAGE_QUADS),
    parameter int PAGE_W      = $clog2(NUM_PAGES),
    parameter int PROT_W      = PAGE_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  word_t             addr,
    input  logic [PROT_W-1:0] prot_thresh,
    input  logic              tgt_marked,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              do_prog,
    output logic              do_erase,
    output logic [QIDX_W-1:0] quad_idx,
    output logic [PAGE_W-1:0] page_idx
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0]  cnt;
    logic [PROT_W-1:0] page_ext;
    logic              locked;
    verdict_e          verdict;
    logic [3:0]        unused_low;

    assign unused_low = addr[3:0];

    // slot index from the aligned address; page index is its upper part
    assign quad_idx = addr[4 +: QIDX_W];
    assign page_idx = quad_idx[QIDX_W-1 -: PAGE_W];
    assign page_ext = PROT_W'(page_idx);
    assign locked   = page_ext < prot_thresh;

    always_comb begin
        case (op)
            OP_PROG_QUAD:
                verdict = locked ? VERDICT_PROT
                        : (tgt_marked ? VERDICT_REPROG : VERDICT_OK);
            OP_ERASE_PAGE:
                verdict = locked ? VERDICT_PROT : VERDICT_OK;
            default:
                verdict = VERDICT_BADOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(BUSY_CYCLES - 1);
        end else if (busy) begin
            if (cnt == '0)
                busy <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end
    end

    assign done     = busy && (cnt == '0);
    assign fail     = (verdict != VERDICT_OK);
    assign do_prog  = done && !fail && (op == OP_PROG_QUAD);
    assign do_erase = done && !fail && (op == OP_ERASE_PAGE);

endmodule

// File: rtl/qwp_array.sv
module qwp_array
    import qwp_pkg::*;
#(
    parameter int NUM_PAGES  = 4,
    parameter int PAGE_QUADS = 4,
    parameter int QIDX_W     = $clog2(NUM_PAGES * PAGE_QUADS),
    parameter int PAGE_W     = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              do_prog,
    input  logic              do_erase,
    input  logic [QIDX_W-1:0] quad_idx,
    input  logic [PAGE_W-1:0] page_idx,
    input  quad_t             wdata,
    input  logic [QIDX_W+1:0] rd_idx,
    output logic              tgt_marked,
    output word_t             rd_word
);

    localparam int NUM_QUADS = NUM_PAGES * PAGE_QUADS;

    quad_t                bank [NUM_QUADS];
    logic [NUM_QUADS-1:0] marks;

    for (genvar q = 0; q < NUM_QUADS; q++) begin : g_slot
        quad_t slot_q;
        logic  mark_q;
        logic  hit_prog;
        logic  hit_erase;

        assign hit_prog  = do_prog  && (quad_idx == QIDX_W'(q));
        assign hit_erase = do_erase && (page_idx == PAGE_W'(q / PAGE_QUADS));

        always_ff @(posedge clk) begin
            if (rst || hit_erase) begin
                slot_q <= ERASED_QUAD;
                mark_q <= 1'b0;
            end else if (hit_prog) begin
                slot_q <= wdata;
                mark_q <= 1'b1;
            end
        end

        assign bank[q]  = slot_q;
        assign marks[q] = mark_q;
    end

    assign tgt_marked = marks[quad_idx];
    assign rd_word    = bank[rd_idx[QIDX_W+1:2]][rd_idx[1:0]];

endmodule

// File: rtl/qwp_flash_ctrl.sv
module qwp_flash_ctrl
    import qwp_pkg::*;
#(
    parameter  int NUM_PAGES   = 4,
    parameter  int PAGE_QUADS  = 4,
    parameter  int BUSY_CYCLES = 16,
    localparam int NUM_QUADS   = NUM_PAGES * PAGE_QUADS,
    localparam int BUS_AW      = $clog2(NUM_QUADS * QUAD_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int QIDX_W = $clog2(NUM_QUADS);
    localparam int PAGE_W = $clog2(NUM_PAGES);
    localparam int PROT_W = PAGE_W + 1;

    op_req_t           req;
    logic [PROT_W-1:0] prot_thresh;
    logic              start;
    logic              werr;
    word_t             reg_rdata;
    logic              busy;
    logic              done;
    logic              fail;
    logic              do_prog;
    logic              do_erase;
    logic [QIDX_W-1:0] quad_idx;
    logic [PAGE_W-1:0] page_idx;
    logic              tgt_marked;
    word_t             flash_word;

    qwp_regs #(
        .BUS_AW (BUS_AW),
        .PROT_W (PROT_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .busy        (busy),
        .done        (done),
        .fail        (fail),
        .req         (req),
        .prot_thresh (prot_thresh),
        .start       (start),
        .werr        (werr),
        .reg_rdata   (reg_rdata)
    );

    qwp_seq #(
        .BUSY_CYCLES (BUSY_CYCLES),
        .NUM_PAGES   (NUM_PAGES),
        .PAGE_QUADS  (PAGE_QUADS),
        .QIDX_W      (QIDX_W),
        .PAGE_W      (PAGE_W),
        .PROT_W      (PROT_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .op          (req.op),
        .addr        (req.addr),
        .prot_thresh (prot_thresh),
        .tgt_marked  (tgt_marked),
        .busy        (busy),
        .done        (done),
        .fail        (fail),
        .do_prog     (do_prog),
        .do_erase    (do_erase),
        .quad_idx    (quad_idx),
        .page_idx    (page_idx)
    );

    qwp_array #(
        .NUM_PAGES  (NUM_PAGES),
        .PAGE_QUADS (PAGE_QUADS),
        .QIDX_W     (QIDX_W),
        .PAGE_W     (PAGE_W)
    ) u_array (
        .clk        (clk),
        .rst        (rst),
        .do_prog    (do_prog),
        .do_erase   (do_erase),
        .quad_idx   (quad_idx),
        .page_idx   (page_idx),
        .wdata      (req.data),
        .rd_idx     (bus_addr[QIDX_W+3:2]),
        .tgt_marked (tgt_marked),
        .rd_word    (flash_word)
    );

    assign bus_rdata = bus_addr[BUS_AW-1] ? flash_word : reg_rdata;

endmodule

// File: rtl/qwp_checker.sv
module qwp_checker
    import qwp_pkg::*;
#(
    parameter int BUS_AW      = 9,
    parameter int PAGE_W      = 2,
    parameter int PROT_W      = 3,
    parameter int BUSY_CYCLES = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              wren_bit,
    input logic              busy,
    input logic              werr,
    input logic              do_prog,
    input logic              do_erase,
    input logic [PAGE_W-1:0] page_idx,
    input logic [PROT_W-1:0] prot_thresh,
    input logic              tgt_marked,
    input word_t             addr_q,
    input quad_t             data_q
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy)
            run_cnt <= '0;
        else
            run_cnt <= run_cnt + 1'b1;
    end

    // R3: the array only changes inside unprotected pages
    a_r3_protected_untouched: assert property (@(posedge clk) disable iff (rst)
        (do_prog || do_erase) |-> (PROT_W'(page_idx) >= prot_thresh));

    // R4: a marked slot is never programmed
    a_r4_no_reprogram: assert property (@(posedge clk) disable iff (rst)
        do_prog |-> !tgt_marked);

    // R5: start without write-enable leaves the block idle
    a_r5_wren_gate: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == '0) && !wren_bit && !busy) |=> !busy);

    // R7: busy never outlasts its window
    a_r7_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_cnt < CNT_W'(BUSY_CYCLES)));

    // R7: busy drops only after the full window
    a_r7_busy_full: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(run_cnt) == CNT_W'(BUSY_CYCLES - 1)));

    // R9: operands are frozen while busy
    a_r9_operands_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(addr_q) && $stable(data_q)));

    // R10: the error flag reads clear as an operation begins
    a_r10_err_cleared: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !werr);

endmodule

bind qwp_flash_ctrl qwp_checker #(
    .BUS_AW      (BUS_AW),
    .PAGE_W      (PAGE_W),
    .PROT_W      (PROT_W),
    .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .wren_bit    (bus_wdata[14]),
    .busy        (busy),
    .werr        (werr),
    .do_prog     (do_prog),
    .do_erase    (do_erase),
    .page_idx    (page_idx),
    .prot_thresh (prot_thresh),
    .tgt_marked  (tgt_marked),
    .addr_q      (req.addr),
    .data_q      (req.data)
);

// File: tb/sim_qwp_flash_ctrl.sv
module sim_qwp_flash_ctrl;

    localparam int NP = 4;
    localparam int PQ = 4;
    localparam int BC = 8;
    localparam int NQ = NP * PQ;
    localparam int NW = NQ * 4;
    localparam int AW = $clog2(NQ * 16) + 1;

    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_ADDR  = 'h04;
    localparam int OFS_DATA  = 'h08;
    localparam int OFS_PROT  = 'h18;
    localparam int FLASH_WIN = 'h100;

    localparam logic [31:0] GO_BITS  = 32'h0000_C000; // start + write-enable
    localparam logic [31:0] BUSY_BIT = 32'h0000_8000;

    typedef struct packed {
        logic [15:0] tag;
        logic [3:0]  op;
        logic [31:0] addr;
        logic [31:0] d0;
        logic [31:0] d1;
        logic [31:0] d2;
        logic [31:0] d3;
        logic        err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{"R1", 4'h2, 32'h40,  32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444, 1'b0},
        '{"R2", 4'h2, 32'h8F,  32'hAAAA_0001, 32'hAAAA_0002, 32'hAAAA_0003, 32'hAAAA_0004, 1'b0},
        '{"R3", 4'h2, 32'h10,  32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1},
        '{"R4", 4'h2, 32'h44,  32'h0,         32'h0,         32'h0,         32'h0,         1'b1},
        '{"R6", 4'h4, 32'h48,  32'h0,         32'h0,         32'h0,         32'h0,         1'b0},
        '{"R6", 4'h2, 32'h40,  32'h5555_0001, 32'h5555_0002, 32'h5555_0003, 32'h5555_0004, 1'b0},
        '{"R3", 4'h4, 32'h20,  32'h0,         32'h0,         32'h0,         32'h0,         1'b1},
        '{"R6", 4'h7, 32'hC0,  32'h7777_7777, 32'h7777_7777, 32'h7777_7777, 32'h7777_7777, 1'b1},
        '{"R1", 4'h2, 32'hF0,  32'hF000_0001, 32'hF000_0002, 32'hF000_0003, 32'hF000_0004, 1'b0},
        '{"R2", 4'h2, 32'h1C0, 32'hC000_0001, 32'hC000_0002, 32'hC000_0003, 32'hC000_0004, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [31:0] model_mem  [NW];
    bit          model_mark [NQ];
    int          model_thresh = 0;

    always #10 clk = ~clk;

    qwp_flash_ctrl #(
        .NUM_PAGES   (NP),
        .PAGE_QUADS  (PQ),
        .BUSY_CYCLES (BC)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int ofs, input logic [31:0] v);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = AW'(ofs);
        bus_wdata = v;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int ofs, output logic [31:0] v);
        bus_we   = 1'b0;
        bus_addr = AW'(ofs);
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_idle(output int busy_n);
        logic [31:0] v;
        busy_n = 0;
        for (int i = 0; i < 1000; i++) begin
            rd(OFS_CTRL, v);
            if (!v[15]) break;
            busy_n++;
            @(negedge clk);
        end
    endtask

    function automatic int slot_of(input logic [31:0] a);
        return int'((a >> 4) % NQ);
    endfunction

    function automatic bit model_run(input logic [3:0] op, input logic [31:0] a,
                                     input logic [31:0] d0, input logic [31:0] d1,
                                     input logic [31:0] d2, input logic [31:0] d3);
        int q;
        int pg;
        q  = slot_of(a);
        pg = q / PQ;
        if (op != 4'h2 && op != 4'h4) return 1'b1;
        if (pg < model_thresh) return 1'b1;
        if (op == 4'h2) begin
            if (model_mark[q]) return 1'b1;
            model_mem[q*4+0] = d0;
            model_mem[q*4+1] = d1;
            model_mem[q*4+2] = d2;
            model_mem[q*4+3] = d3;
            model_mark[q]    = 1'b1;
        end else begin
            for (int s = pg * PQ; s < (pg + 1) * PQ; s++) begin
                for (int k = 0; k < 4; k++) model_mem[s*4+k] = 32'hFFFF_FFFF;
                model_mark[s] = 1'b0;
            end
        end
        return 1'b0;
    endfunction

    task automatic load_operands(input logic [31:0] a, input logic [31:0] d0,
                                 input logic [31:0] d1, input logic [31:0] d2,
                                 input logic [31:0] d3);
        wr(OFS_ADDR, a);
        wr(OFS_DATA + 0,  d0);
        wr(OFS_DATA + 4,  d1);
        wr(OFS_DATA + 8,  d2);
        wr(OFS_DATA + 12, d3);
    endtask

    task automatic check_slot(input string req, input logic [31:0] a);
        logic [31:0] v;
        int q;
        q = slot_of(a);
        for (int k = 0; k < 4; k++) begin
            rd(FLASH_WIN + q*16 + k*4, v);
            chk(req, v, model_mem[q*4+k]);
        end
    endtask

    task automatic run_op(input string req, input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] d0, input logic [31:0] d1,
                          input logic [31:0] d2, input logic [31:0] d3,
                          output bit err_seen);
        logic [31:0] v;
        int busy_n;
        bit exp_err;
        load_operands(a, d0, d1, d2, d3);
        wr(OFS_CTRL, GO_BITS | 32'(op));
        wait_idle(busy_n);
        chk("R7 busy length", 32'(busy_n), 32'(BC));
        exp_err = model_run(op, a, d0, d1, d2, d3);
        rd(OFS_CTRL, v);
        err_seen = v[13];
        chk({req, " error flag"}, 32'(v[13]), 32'(exp_err));
        chk("R10 low-voltage flag", 32'(v[12]), 32'h0);
        check_slot({req, " contents"}, a);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit          e;
        int          busy_n;

        for (int i = 0; i < NW; i++) model_mem[i] = 32'hFFFF_FFFF;
        for (int i = 0; i < NQ; i++) model_mark[i] = 1'b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8: reset state
        rd(OFS_CTRL, v);          chk("R8 ctrl reset", v, 32'h0);
        rd(OFS_ADDR, v);          chk("R8 addr reset", v, 32'h0);
        rd(OFS_DATA + 12, v);     chk("R8 data3 reset", v, 32'h0);
        rd(OFS_PROT, v);          chk("R8 threshold reset", v, 32'h0);
        rd(FLASH_WIN, v);         chk("R8 first word erased", v, 32'hFFFF_FFFF);
        rd(FLASH_WIN + 'hFC, v);  chk("R8 last word erased", v, 32'hFFFF_FFFF);

        // R11: register readback and read-only flash window
        wr(OFS_ADDR, 32'h1234_5678);
        rd(OFS_ADDR, v);          chk("R11 addr readback", v, 32'h1234_5678);
        wr(OFS_DATA + 8, 32'hCAFE_0002);
        rd(OFS_DATA + 8, v);      chk("R11 data2 readback", v, 32'hCAFE_0002);
        wr(FLASH_WIN + 'h30, 32'h0);
        rd(FLASH_WIN + 'h30, v);  chk("R11 flash window write ignored", v, 32'hFFFF_FFFF);
        wr(OFS_PROT, 32'h1);
        model_thresh = 1;
        rd(OFS_PROT, v);          chk("R11 threshold readback", v, 32'h1);

        // table of operations, page 0 protected
        for (int i = 0; i < NV; i++) begin
            run_op(string'(VECS[i].tag), VECS[i].op, VECS[i].addr,
                   VECS[i].d0, VECS[i].d1, VECS[i].d2, VECS[i].d3, e);
            chk({string'(VECS[i].tag), " table error"}, 32'(e), 32'(VECS[i].err));
        end

        // R5: start without write-enable does nothing
        load_operands(32'h80, 32'h5A5A_5A5A, 32'h5A5A_5A5A, 32'h5A5A_5A5A, 32'h5A5A_5A5A);
        wr(OFS_CTRL, BUSY_BIT | 32'h2);
        rd(OFS_CTRL, v);          chk("R5 busy stays low", 32'(v[15]), 32'h0);
        repeat (BC + 2) @(negedge clk);
        check_slot("R5 array unchanged", 32'h80);

        // R9: writes during busy are ignored
        load_operands(32'hD0, 32'h600D_0000, 32'h600D_0001, 32'h600D_0002, 32'h600D_0003);
        wr(OFS_CTRL, GO_BITS | 32'h2);
        wr(OFS_ADDR, 32'hE0);
        wr(OFS_DATA, 32'h0BAD_0BAD);
        wr(OFS_PROT, 32'h4);
        wait_idle(busy_n);
        e = model_run(4'h2, 32'hD0, 32'h600D_0000, 32'h600D_0001, 32'h600D_0002, 32'h600D_0003);
        rd(OFS_ADDR, v);          chk("R9 addr kept", v, 32'hD0);
        rd(OFS_DATA, v);          chk("R9 data0 kept", v, 32'h600D_0000);
        rd(OFS_PROT, v);          chk("R9 threshold kept", v, 32'h1);
        check_slot("R9 old operands used", 32'hD0);
        check_slot("R9 other slot untouched", 32'hE0);

        // R10: error flag clears as a new operation starts
        run_op("R3", 4'h2, 32'h30, 32'h1, 32'h2, 32'h3, 32'h4, e);
        chk("R10 error raised first", 32'(e), 32'h1);
        load_operands(32'hE0, 32'hE000_0001, 32'hE000_0002, 32'hE000_0003, 32'hE000_0004);
        wr(OFS_CTRL, GO_BITS | 32'h2);
        rd(OFS_CTRL, v);
        chk("R10 busy after start", 32'(v[15]), 32'h1);
        chk("R10 error cleared at start", 32'(v[13]), 32'h0);
        wait_idle(busy_n);
        e = model_run(4'h2, 32'hE0, 32'hE000_0001, 32'hE000_0002, 32'hE000_0003, 32'hE000_0004);
        check_slot("R10 program after error", 32'hE0);

        // R3: threshold boundaries
        wr(OFS_PROT, 32'h0);
        model_thresh = 0;
        run_op("R3 threshold 0", 4'h2, 32'h00, 32'h0000_0A01, 32'h0000_0A02,
               32'h0000_0A03, 32'h0000_0A04, e);
        wr(OFS_PROT, 32'(NP));
        model_thresh = NP;
        run_op("R3 all pages locked", 4'h4, 32'hC0, 32'h0, 32'h0, 32'h0, 32'h0, e);
        run_op("R3 all pages locked prog", 4'h2, 32'h70, 32'h1, 32'h1, 32'h1, 32'h1, e);

        // R1: full sweep of the array
        for (int w = 0; w < NW; w++) begin
            rd(FLASH_WIN + w*4, v);
            chk("R1 sweep", v, model_mem[w]);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule